// File: doc/BRIEF.md
# Four-Lane DSI Video Packet Decoder

This block sits behind a D-PHY receiver that has already turned four high-speed data lanes into aligned bytes. Each clock, while a high-speed burst is active, it takes one byte from every physical lane. It puts the lanes into a programmable logical order and undoes any swapped differential pairs. It then reads the result as a single byte stream, where byte n of the burst comes from logical lane n mod 4.

A packet parser walks that stream four bytes per clock. Short sync-event packets become single-cycle vsync and hsync start and end strobes. Pixel payloads in packed 24-bit or loosely packed 18-bit form become RGB888 pixels. Because four bytes can complete two pixels, the pixel port has two slots per clock.

Null packets, blanking packets and end-of-transmission packets are consumed without output. The virtual-channel bits, the header ECC byte and the payload checksum are never checked. Any other data type sets a sticky error flag, and the rest of that burst is skipped.

Top module: `dsi_vid_decoder`

## Requirements
- R1: Field `lane_sel[2k+1:2k]` names the physical lane that feeds logical lane k. In one clock, the byte of logical lane 0 is the earliest in stream order and that of logical lane 3 the latest.
- R2: When bit p of `lane_inv` is set, every bit of the byte received on physical lane p is inverted before any other use.
- R3: Data types 0x01, 0x11, 0x21 and 0x31 (bits [5:0] of the first header byte) pulse `vs_start`, `vs_end`, `hs_start` and `hs_end` for one cycle. Bits [7:6] and the three remaining header bytes are ignored. Outputs for a group of bytes sampled at one rising edge appear after the next rising edge.
- R4: For type 0x3E, each three payload bytes form one pixel, output as {first, second, third} in bits [23:16], [15:8] and [7:0]. The header word count (bytes 2 and 3, little-endian) sets the payload length, and payload bytes left over after the last whole pixel are dropped.
- R5: For type 0x2E, each payload byte carries a 6-bit component in bits [7:2]. That component c is output as the 8-bit value {c, c[5:4]}.
- R6: `pix_valid` is 2'b00, 2'b01 or 2'b11, never 2'b10. Slot 0 (`pix_data[23:0]`) precedes slot 1 (`pix_data[47:24]`) in stream order. A pixel is never output in the same cycle as a sync strobe.
- R7: Types 0x09 and 0x19 consume their payload, and 0x08 is a four-byte packet. None of the three gives any output. The two bytes after every long payload are skipped unchecked, and the next header follows at once in the same burst.
- R8: Any other data type sets `fmt_err`, and every later byte of that burst gives no output. The next burst is parsed normally, and `fmt_err` clears only through reset.
- R9: When `hs_active` is low, the parser drops any partial packet and looks for a header at the next burst. All strobes and `pix_valid` are low two cycles later.
- R10: While `rst` is high, all outputs are held low from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_active | input | 1 | High while a high-speed burst delivers valid lane bytes |
| lane_data | input | 32 | Byte of physical lane p in bits [8p+7:8p] |
| lane_sel | input | 8 | Physical source of each logical lane, two bits per logical lane |
| lane_inv | input | 4 | Per physical lane bit inversion enable |
| pix_valid | output | 2 | Pixel slot valids |
| pix_data | output | 48 | Slot 0 RGB in [23:0], slot 1 RGB in [47:24] |
| vs_start | output | 1 | Vsync start strobe |
| vs_end | output | 1 | Vsync end strobe |
| hs_start | output | 1 | Hsync start strobe |
| hs_end | output | 1 | Hsync end strobe |
| fmt_err | output | 1 | Sticky unsupported data type flag |

## Verification
The hardest states to reach are those where packet edges fall at every offset inside a four-byte group. Only then do two pixels complete in one clock, or a header start in the middle of a group right after a checksum.

The stimulus builds bursts from packets of chosen word counts (3, 5, 7, 9 and 12 bytes) so that headers and pixel boundaries move through all four lane positions. Each burst is finished by a null packet sized to the group boundary, so that no stray header is seen. One burst is cut in the middle of a long payload to show that the parser starts again at the next burst.

// File: rtl/dsi_vid_pkg.sv
package dsi_vid_pkg;

    localparam int LANES     = 4;
    localparam int BYTE_W    = 8;
    localparam int SEL_W     = $clog2(LANES);
    localparam int PIX_W     = 24;
    localparam int PIX_SLOTS = 2;
    localparam int WC_W      = 16;

    localparam logic [5:0] DT_VS_START = 6'h01;
    localparam logic [5:0] DT_VS_END   = 6'h11;
    localparam logic [5:0] DT_HS_START = 6'h21;
    localparam logic [5:0] DT_HS_END   = 6'h31;
    localparam logic [5:0] DT_EOT      = 6'h08;
    localparam logic [5:0] DT_NULL     = 6'h09;
    localparam logic [5:0] DT_BLANK    = 6'h19;
    localparam logic [5:0] DT_RGB18L   = 6'h2E;
    localparam logic [5:0] DT_RGB24    = 6'h3E;

    typedef logic [LANES-1:0][BYTE_W-1:0] lane_bytes_t;
    typedef logic [PIX_SLOTS-1:0][PIX_W-1:0] pix_pair_t;

    typedef enum logic [1:0] {
        PS_HDR  = 2'd0,
        PS_PAY  = 2'd1,
        PS_CRC  = 2'd2,
        PS_DROP = 2'd3
    } pstate_e;

    typedef struct packed {
        logic hs_end;
        logic hs_start;
        logic vs_end;
        logic vs_start;
    } sync_t;

    typedef struct packed {
        pstate_e           st;
        logic [1:0]        hidx;
        logic [BYTE_W-1:0] di;
        logic [BYTE_W-1:0] wc_lo;
        logic [WC_W-1:0]   rem;
        logic [1:0]        pidx;
        logic [BYTE_W-1:0] c0;
        logic [BYTE_W-1:0] c1;
        logic              cidx;
    } pctx_t;

    function automatic logic is_long_ok(input logic [5:0] dt);
        return (dt == DT_NULL) || (dt == DT_BLANK) ||
               (dt == DT_RGB18L) || (dt == DT_RGB24);
    endfunction

    function automatic logic is_pix_type(input logic [5:0] dt);
        return (dt == DT_RGB18L) || (dt == DT_RGB24);
    endfunction

    function automatic logic [BYTE_W-1:0] widen6(input logic [BYTE_W-1:0] b);
        return {b[7:2], b[7:6]};
    endfunction

    function automatic logic [PIX_W-1:0] make_pixel(
        input logic              loose18,
        input logic [BYTE_W-1:0] a,
        input logic [BYTE_W-1:0] b,
        input logic [BYTE_W-1:0] c
    );
        if (loose18)
            return {widen6(a), widen6(b), widen6(c)};
        return {a, b, c};
    endfunction

endpackage

// File: rtl/dsi_lane_merge.sv
module dsi_lane_merge
    import dsi_vid_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   burst_in,
    input  lane_bytes_t            phys_bytes,
    input  logic [LANES*SEL_W-1:0] lane_sel,
    input  logic [LANES-1:0]       lane_inv,
    output logic                   grp_vld,
    output lane_bytes_t            grp_bytes
);

    lane_bytes_t logical;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SEL_W-1:0] src;
        assign src        = lane_sel[k*SEL_W +: SEL_W];
        assign logical[k] = phys_bytes[src] ^ {BYTE_W{lane_inv[src]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_vld   <= 1'b0;
            grp_bytes <= '0;
        end else begin
            grp_vld   <= burst_in;
            grp_bytes <= burst_in ? logical : '0;
        end
    end

endmodule

// File: rtl/dsi_pkt_parser.sv
module dsi_pkt_parser
    import dsi_vid_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 grp_vld,
    input  lane_bytes_t          grp_bytes,
    output logic [PIX_SLOTS-1:0] pix_vld,
    output pix_pair_t            pix_out,
    output sync_t                sync_out,
    output logic                 err_flag
);

    pctx_t                cur;
    pctx_t                nx;
    logic [PIX_SLOTS-1:0] pv_n;
    pix_pair_t            px_n;
    sync_t                sy_n;
    logic                 bad_n;

    always_comb begin
        logic [BYTE_W-1:0] b;
        logic [5:0]        dt;
        logic [1:0]        n_pix;
        nx    = cur;
        pv_n  = '0;
        px_n  = '0;
        sy_n  = '0;
        bad_n = 1'b0;
        b     = '0;
        dt    = '0;
        n_pix = '0;
        if (!grp_vld) begin
            nx = '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                b  = grp_bytes[i];
                dt = nx.di[5:0];
                case (nx.st)
                    PS_HDR: begin
                        case (nx.hidx)
                            2'd0: nx.di    = b;
                            2'd1: nx.wc_lo = b;
                            2'd2: nx.rem   = {b, nx.wc_lo};
                            default: begin
                                if (dt == DT_VS_START)      sy_n.vs_start = 1'b1;
                                else if (dt == DT_VS_END)   sy_n.vs_end   = 1'b1;
                                else if (dt == DT_HS_START) sy_n.hs_start = 1'b1;
                                else if (dt == DT_HS_END)   sy_n.hs_end   = 1'b1;
                                else if (dt == DT_EOT)      nx.st = PS_HDR;
                                else if (is_long_ok(dt)) begin
                                    nx.pidx = '0;
                                    nx.cidx = 1'b0;
                                    nx.st   = (nx.rem == '0) ? PS_CRC : PS_PAY;
                                end else begin
                                    bad_n = 1'b1;
                                    nx.st = PS_DROP;
                                end
                            end
                        endcase
                        nx.hidx = nx.hidx + 2'd1;
                    end
                    PS_PAY: begin
                        if (is_pix_type(dt)) begin
                            case (nx.pidx)
                                2'd0: begin nx.c0 = b; nx.pidx = 2'd1; end
                                2'd1: begin nx.c1 = b; nx.pidx = 2'd2; end
                                default: begin
                                    pv_n[n_pix[0]] = 1'b1;
                                    px_n[n_pix[0]] = make_pixel(dt == DT_RGB18L,
                                                                nx.c0, nx.c1, b);
                                    n_pix   = n_pix + 2'd1;
                                    nx.pidx = 2'd0;
                                end
                            endcase
                        end
                        if (nx.rem == 16'd1) begin
                            nx.st   = PS_CRC;
                            nx.cidx = 1'b0;
                        end
                        nx.rem = nx.rem - 16'd1;
                    end
                    PS_CRC: begin
                        if (nx.cidx) nx.st = PS_HDR;
                        nx.cidx = 1'b1;
                    end
                    default: nx.st = PS_DROP;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            pix_vld  <= '0;
            pix_out  <= '0;
            sync_out <= '0;
            err_flag <= 1'b0;
        end else begin
            cur      <= nx;
            pix_vld  <= pv_n;
            pix_out  <= px_n;
            sync_out <= sy_n;
            err_flag <= err_flag | bad_n;
        end
    end

endmodule

// File: rtl/dsi_vid_decoder.sv
module dsi_vid_decoder
    import dsi_vid_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         hs_active,
    input  logic [LANES*BYTE_W-1:0]      lane_data,
    input  logic [LANES*SEL_W-1:0]       lane_sel,
    input  logic [LANES-1:0]             lane_inv,
    output logic [PIX_SLOTS-1:0]         pix_valid,
    output logic [PIX_SLOTS*PIX_W-1:0]   pix_data,
    output logic                         vs_start,
    output logic                         vs_end,
    output logic                         hs_start,
    output logic                         hs_end,
    output logic                         fmt_err
);

    logic        grp_vld;
    lane_bytes_t grp_bytes;
    pix_pair_t   pix_pair;
    sync_t       sync_s;

    dsi_lane_merge u_merge (
        .clk        (clk),
        .rst        (rst),
        .burst_in   (hs_active),
        .phys_bytes (lane_data),
        .lane_sel   (lane_sel),
        .lane_inv   (lane_inv),
        .grp_vld    (grp_vld),
        .grp_bytes  (grp_bytes)
    );

    dsi_pkt_parser u_parse (
        .clk       (clk),
        .rst       (rst),
        .grp_vld   (grp_vld),
        .grp_bytes (grp_bytes),
        .pix_vld   (pix_valid),
        .pix_out   (pix_pair),
        .sync_out  (sync_s),
        .err_flag  (fmt_err)
    );

    assign pix_data = pix_pair;
    assign vs_start = sync_s.vs_start;
    assign vs_end   = sync_s.vs_end;
    assign hs_start = sync_s.hs_start;
    assign hs_end   = sync_s.hs_end;

endmodule

// File: rtl/dsi_vid_decoder_chk.sv
module dsi_vid_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       hs_active,
    input logic [1:0] pix_valid,
    input logic       vs_start,
    input logic       vs_end,
    input logic       hs_start,
    input logic       hs_end,
    input logic       fmt_err
);

    logic [3:0] syncs;
    assign syncs = {hs_end, hs_start, vs_end, vs_start};

    AST_PIX_PACKED: assert property (@(posedge clk) disable iff (rst)
        pix_valid != 2'b10); // R6

    AST_SYNC_NO_PIX: assert property (@(posedge clk) disable iff (rst)
        (syncs != 4'b0000) |-> (pix_valid == 2'b00)); // R6

    AST_SYNC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(syncs)); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        fmt_err |=> fmt_err); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !hs_active |-> ##2 ((pix_valid == 2'b00) && (syncs == 4'b0000))); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> ((pix_valid == 2'b00) && (syncs == 4'b0000) && !fmt_err)); // R10

endmodule

bind dsi_vid_decoder dsi_vid_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hs_active (hs_active),
    .pix_valid (pix_valid),
    .vs_start  (vs_start),
    .vs_end    (vs_end),
    .hs_start  (hs_start),
    .hs_end    (hs_end),
    .fmt_err   (fmt_err)
);

// File: tb/dsi_vid_decoder_bench.sv
`timescale 1ns/1ps
module dsi_vid_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_active = 1'b0;
    logic [31:0] lane_data = '0;
    logic [7:0]  lane_sel = 8'hE4;
    logic [3:0]  lane_inv = 4'h0;
    logic [1:0]  pix_valid;
    logic [47:0] pix_data;
    logic        vs_start, vs_end, hs_start, hs_end, fmt_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dsi_vid_decoder u_dsi_vid_decoder (
        .clk(clk), .rst(rst), .hs_active(hs_active), .lane_data(lane_data),
        .lane_sel(lane_sel), .lane_inv(lane_inv), .pix_valid(pix_valid),
        .pix_data(pix_data), .vs_start(vs_start), .vs_end(vs_end),
        .hs_start(hs_start), .hs_end(hs_end), .fmt_err(fmt_err)
    );

    // stream under construction
    logic [7:0] pq[$];

    // behavioural reference state
    int         m_mode, m_h, m_wc, m_pc, m_cc;
    logic [7:0] m_di;
    logic [7:0] m_pb[3];
    bit         m_err = 0;
    logic [3:0]  g_sync;
    logic [23:0] g_pix[$];
    logic [1:0]  e_pv[$];
    logic [23:0] e_p0[$], e_p1[$];
    logic [3:0]  e_st[$];
    logic        e_er[$];

    function automatic logic [7:0] w6(input logic [7:0] b);
        return {b[7:2], b[7:6]};
    endfunction

    task automatic m_byte(input logic [7:0] b);
        logic [5:0] dt;
        dt = m_di[5:0];
        if (m_mode == 0) begin
            if (m_h == 0) m_di = b;
            else if (m_h == 1) m_wc = b;
            else if (m_h == 2) m_wc = m_wc + 256 * b;
            else begin
                if (dt == 6'h01) g_sync = 4'b0001;          // R3
                else if (dt == 6'h11) g_sync = 4'b0010;
                else if (dt == 6'h21) g_sync = 4'b0100;
                else if (dt == 6'h31) g_sync = 4'b1000;
                else if (dt == 6'h08) ;                      // R7
                else if (dt == 6'h09 || dt == 6'h19 || dt == 6'h2E || dt == 6'h3E) begin
                    m_pc = 0; m_cc = 0;
                    m_mode = (m_wc == 0) ? 2 : 1;
                end else begin
                    m_err = 1; m_mode = 3;                   // R8
                end
            end
            m_h = (m_h + 1) % 4;
        end else if (m_mode == 1) begin
            if (dt == 6'h3E || dt == 6'h2E) begin
                m_pb[m_pc] = b;
                m_pc++;
                if (m_pc == 3) begin
                    if (dt == 6'h3E) g_pix.push_back({m_pb[0], m_pb[1], m_pb[2]});      // R4
                    else g_pix.push_back({w6(m_pb[0]), w6(m_pb[1]), w6(m_pb[2])});    // R5
                    m_pc = 0;
                end
            end
            m_wc--;
            if (m_wc == 0) begin m_mode = 2; m_cc = 0; end
        end else if (m_mode == 2) begin
            m_cc++;
            if (m_cc == 2) m_mode = 0;
        end
    endtask

    task automatic put_short(input logic [7:0] di);
        pq.push_back(di); pq.push_back(8'h5A); pq.push_back(8'hC3); pq.push_back(8'h77);
    endtask

    task automatic put_long(input logic [7:0] di, input int wc, input int seed);
        pq.push_back(di); pq.push_back(wc[7:0]); pq.push_back(wc[15:8]); pq.push_back(8'h6B);
        for (int i = 0; i < wc; i++) pq.push_back(8'((seed + i * 37 + (i * i) * 11) % 256));
        pq.push_back(8'hE1); pq.push_back(8'h1E);
    endtask

    task automatic pad4();
        if (pq.size() % 4 != 0) put_long(8'h09, (4 - (pq.size() + 6) % 4) % 4, 0);
    endtask

    task automatic cmp(input string tag, input logic [1:0] epv, input logic [23:0] ep0,
                       input logic [23:0] ep1, input logic [3:0] est, input logic eer);
        logic [3:0] ast;
        bit bad;
        ast = {hs_end, hs_start, vs_end, vs_start};
        bad = (pix_valid !== epv) || (ast !== est) || (fmt_err !== eer) ||
              (epv[0] && pix_data[23:0] !== ep0) || (epv[1] && pix_data[47:24] !== ep1);
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: pv=%b/%b p0=%h/%h p1=%h/%h sync=%b/%b err=%b/%b (actual/expected)",
                     tag, pix_valid, epv, pix_data[23:0], ep0, pix_data[47:24], ep1,
                     ast, est, fmt_err, eer);
        end
    endtask

    task automatic run_burst(input string tag, input logic [7:0] sel,
                             input logic [3:0] inv, input int cut);
        int  ngr;
        bit  err0;
        logic [31:0] ld;
        err0 = m_err;
        m_mode = 0; m_h = 0; m_wc = 0; m_pc = 0; m_cc = 0; m_di = '0;
        ngr = (cut > 0) ? cut : pq.size() / 4;
        e_pv.delete(); e_p0.delete(); e_p1.delete(); e_st.delete(); e_er.delete();
        for (int g = 0; g < ngr; g++) begin
            g_sync = '0; g_pix.delete();
            for (int k = 0; k < 4; k++) m_byte(pq[4*g+k]);   // R1: logical 0 first
            e_pv.push_back(g_pix.size() == 0 ? 2'b00 : (g_pix.size() == 1 ? 2'b01 : 2'b11));
            e_p0.push_back(g_pix.size() > 0 ? g_pix[0] : 24'h0);
            e_p1.push_back(g_pix.size() > 1 ? g_pix[1] : 24'h0);
            e_st.push_back(g_sync);
            e_er.push_back(m_err);
        end
        for (int c = 0; c < ngr + 2; c++) begin
            @(negedge clk);
            if (c >= 2) cmp(tag, e_pv[c-2], e_p0[c-2], e_p1[c-2], e_st[c-2], e_er[c-2]);
            else cmp({tag, " idle R9"}, 2'b00, 24'h0, 24'h0, 4'b0000, err0);
            if (c < ngr) begin
                ld = '0;
                for (int k = 0; k < 4; k++) begin
                    int p;
                    p = sel[2*k +: 2];
                    ld[8*p +: 8] = pq[4*c+k] ^ {8{inv[p]}};   // R2
                end
                lane_sel = sel; lane_inv = inv; lane_data = ld; hs_active = 1'b1;
            end else begin
                hs_active = 1'b0; lane_data = 32'hDEAD_BEEF;
            end
        end
        pq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp("R10 reset", 2'b00, 24'h0, 24'h0, 4'b0000, 1'b0);
        rst = 1'b0;

        // R3 R4 R6 R7: identity order, sync with channel bits set, pixels in all slots
        put_short(8'h01); put_short(8'hA1);
        put_long(8'h3E, 12, 5);
        put_short(8'h71);
        put_long(8'h09, 3, 9); put_long(8'h19, 5, 3);
        put_long(8'hFE, 7, 77);
        put_short(8'h11); put_short(8'h08);
        pad4();
        run_burst("R3 R4 R6 R7", 8'hE4, 4'b0000, 0);

        // R1 R2 R5: shuffled lanes, two lanes inverted, loosely packed pixels
        put_short(8'h41);
        put_long(8'h2E, 9, 201);
        put_long(8'h19, 2, 1);
        put_long(8'hAE, 6, 90);
        put_short(8'h11);
        pad4();
        run_burst("R1 R2 R5", 8'h72, 4'b1010, 0);

        // R8: unsupported type mid burst, rest ignored
        put_short(8'h21); put_long(8'h3E, 6, 17);
        put_short(8'h29);
        put_short(8'h31); put_long(8'h3E, 6, 40);
        pad4();
        run_burst("R8 drop", 8'h1B, 4'b0001, 0);

        // R8: next burst parses normally, flag stays set
        put_short(8'h21); put_long(8'h3E, 3, 60); pad4();
        run_burst("R8 next", 8'hE4, 4'b1111, 0);

        // R10 R8: reset clears the flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        cmp("R10 R8 clear", 2'b00, 24'h0, 24'h0, 4'b0000, 1'b0);
        rst = 1'b0; m_err = 0;

        // R9: burst cut inside a long payload, then a fresh burst
        put_long(8'h3E, 60, 123);
        run_burst("R9 cut", 8'h4E, 4'b0100, 3);
        put_short(8'h31); put_long(8'h3E, 3, 8); put_short(8'h01); pad4();
        run_burst("R9 resume", 8'h4E, 4'b0100, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule